// File: doc/BRIEF.md
# Chained Unsigned Magnitude Comparator

This block compares two unsigned words and reports whether the first is below, equal to or above the second. The word is split into fixed-width slices (four bits by default). Each slice decides on its own bits, and it passes its verdict upward through three relation lines. A slice defers to the relation lines coming from below only when its own bits are equal. The least significant slice takes the relation lines from the block's cascade inputs. The most significant slice drives the block's three outputs. When the cascade inputs are held at "equal", the block acts as a plain word comparator. When they carry the verdict of a lower-order block, several blocks chain into a still wider comparator.

Beside the slice chain, a separate bit-serial equality chain walks the word one bit at a time. Each cell passes an "equal so far" flag to the next cell, and the first cell is seeded with 1. The last flag gives an equality-only result that does not depend on the cascade inputs. The whole block is combinational, so its outputs follow its inputs with no clock edge.

Top module: `mag_cmp_chain`

## Requirements
- R1: `less_o` is 1 exactly when A < B (unsigned), or when A == B and `casc_less_i` is 1.
- R2: `more_o` is 1 exactly when A > B (unsigned), or when A == B and `casc_more_i` is 1.
- R3: `same_o` is 1 exactly when A == B and `casc_same_i` is 1.
- R4: A difference in a more significant slice decides the outputs whatever the lower slices and the cascade inputs hold. Slice k covers bits [4k+3:4k] with the default parameters.
- R5: `bits_eq_o` is 1 exactly when A == B, whatever the three cascade inputs are.
- R6: If any single bit of A differs from the same bit of B, `bits_eq_o` is 0, whichever bit it is and whatever the other bits hold.
- R7: When the three cascade inputs are one-hot, exactly one of `less_o`, `same_o`, `more_o` is 1.
- R8: When A == B, the three outputs copy the three cascade inputs, even if those inputs are not one-hot (all 0 or all 1).
- R9: The outputs settle from the inputs with no clock edge, so a change in the inputs shows at the outputs within the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | SLICE_W*N_SLICES | Operand A, unsigned |
| b_i | input | SLICE_W*N_SLICES | Operand B, unsigned |
| casc_less_i | input | 1 | Relation "less" from a lower-order stage |
| casc_same_i | input | 1 | Relation "equal" from a lower-order stage |
| casc_more_i | input | 1 | Relation "greater" from a lower-order stage |
| less_o | output | 1 | A below B, or equal words with less carried in |
| same_o | output | 1 | Equal words with equal carried in |
| more_o | output | 1 | A above B, or equal words with greater carried in |
| bits_eq_o | output | 1 | Word equality from the bit-serial chain |

## Verification
The low slice is swept through every pair of nibbles while the high slice holds equal values. This is done under each one-hot cascade setting, so that a slice deciding on its own bits can be told apart from one that wrongly passes the cascade through. The same sweep on the high slice, with unequal low nibbles and opposite cascade inputs, shows whether the upper slice really takes priority. Single-bit flips at every position test the equality chain's handling of a mismatch at the start, middle or end. All-zero and all-one cascade inputs on equal words show whether the cascade inputs pass through one by one rather than being treated as a single encoded verdict. Seeded random words fill in the remaining space.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;
  // Three relation lines carried between slices
  typedef struct packed {
    logic less;
    logic same;
    logic more;
  } rel_t;
endpackage

// File: rtl/cmp_slice.sv
module cmp_slice
  import mag_cmp_pkg::*;
#(
  parameter int SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] a_i,
  input  logic [SLICE_W-1:0] b_i,
  input  rel_t               rel_i,
  output rel_t               rel_o
);
  logic loc_lt, loc_gt, loc_eq;

  // Scan from the top bit down: the first differing bit decides
  always_comb begin
    loc_lt = 1'b0;
    loc_gt = 1'b0;
    for (int i = SLICE_W - 1; i >= 0; i--) begin
      if (!loc_lt && !loc_gt) begin
        if (a_i[i] && !b_i[i])      loc_gt = 1'b1;
        else if (!a_i[i] && b_i[i]) loc_lt = 1'b1;
      end
    end
    loc_eq = !loc_lt && !loc_gt;
  end

  // Lower-order relation matters only on a local tie
  assign rel_o.less = loc_lt | (loc_eq & rel_i.less);
  assign rel_o.more = loc_gt | (loc_eq & rel_i.more);
  assign rel_o.same = loc_eq & rel_i.same;
endmodule

// File: rtl/eq_bit_cell.sv
module eq_bit_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic eq_in,
  output logic eq_out
);
  assign eq_out = eq_in & ~(x_i ^ y_i);
endmodule

// File: rtl/eq_bit_chain.sv
module eq_bit_chain #(
  parameter int N_BITS = 8
) (
  input  logic [N_BITS-1:0] x_i,
  input  logic [N_BITS-1:0] y_i,
  output logic              eq_o
);
  logic [N_BITS:0] link;

  assign link[0] = 1'b1;

  for (genvar k = 0; k < N_BITS; k++) begin : g_cell
    eq_bit_cell u_cell (
      .x_i   (x_i[k]),
      .y_i   (y_i[k]),
      .eq_in (link[k]),
      .eq_out(link[k+1])
    );
  end

  assign eq_o = link[N_BITS];
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import mag_cmp_pkg::*;
#(
  parameter int SLICE_W  = 4,
  parameter int N_SLICES = 2
) (
  input  logic [SLICE_W*N_SLICES-1:0] a_i,
  input  logic [SLICE_W*N_SLICES-1:0] b_i,
  input  logic                        casc_less_i,
  input  logic                        casc_same_i,
  input  logic                        casc_more_i,
  output logic                        less_o,
  output logic                        same_o,
  output logic                        more_o,
  output logic                        bits_eq_o
);
  localparam int WORD_W = SLICE_W * N_SLICES;

  rel_t link [0:N_SLICES];

  assign link[0] = '{less: casc_less_i, same: casc_same_i, more: casc_more_i};

  // Low slice first; each slice feeds the next more significant one
  for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
    cmp_slice #(.SLICE_W(SLICE_W)) u_slice (
      .a_i  (a_i[s*SLICE_W +: SLICE_W]),
      .b_i  (b_i[s*SLICE_W +: SLICE_W]),
      .rel_i(link[s]),
      .rel_o(link[s+1])
    );
  end

  assign less_o = link[N_SLICES].less;
  assign same_o = link[N_SLICES].same;
  assign more_o = link[N_SLICES].more;

  eq_bit_chain #(.N_BITS(WORD_W)) u_eqc (
    .x_i(a_i),
    .y_i(b_i),
    .eq_o(bits_eq_o)
  );
endmodule

// File: rtl/mag_cmp_chain_chk.sv
module mag_cmp_chain_chk #(
  parameter int SLICE_W  = 4,
  parameter int N_SLICES = 2
) (
  input logic [SLICE_W*N_SLICES-1:0] a_i,
  input logic [SLICE_W*N_SLICES-1:0] b_i,
  input logic                        casc_less_i,
  input logic                        casc_same_i,
  input logic                        casc_more_i,
  input logic                        less_o,
  input logic                        same_o,
  input logic                        more_o,
  input logic                        bits_eq_o
);
  always_comb begin
    a_r1_less: assert (less_o == ((a_i < b_i) || ((a_i == b_i) && casc_less_i)))
      else $error("R1 less_o mismatch");
    a_r2_more: assert (more_o == ((a_i > b_i) || ((a_i == b_i) && casc_more_i)))
      else $error("R2 more_o mismatch");
    a_r3_same: assert (same_o == ((a_i == b_i) && casc_same_i))
      else $error("R3 same_o mismatch");
    a_r5_bits_eq: assert (bits_eq_o == (a_i == b_i))
      else $error("R5 bits_eq_o mismatch");
    if ($onehot({casc_less_i, casc_same_i, casc_more_i})) begin
      a_r7_one_out: assert ($onehot({less_o, same_o, more_o}))
        else $error("R7 outputs not one-hot");
    end
  end
endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.SLICE_W(SLICE_W), .N_SLICES(N_SLICES)) u_chk (
  .a_i        (a_i),
  .b_i        (b_i),
  .casc_less_i(casc_less_i),
  .casc_same_i(casc_same_i),
  .casc_more_i(casc_more_i),
  .less_o     (less_o),
  .same_o     (same_o),
  .more_o     (more_o),
  .bits_eq_o  (bits_eq_o)
);

// File: tb/mag_cmp_chain_test.sv
`timescale 1ns/1ps
module mag_cmp_chain_test;
  localparam int SW = 4;
  localparam int NS = 2;
  localparam int W  = SW * NS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [W-1:0] a, b;
  logic cl, ce, cg;
  logic lt, eq, gt, weq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  mag_cmp_chain #(.SLICE_W(SW), .N_SLICES(NS)) uut (
    .a_i(a), .b_i(b),
    .casc_less_i(cl), .casc_same_i(ce), .casc_more_i(cg),
    .less_o(lt), .same_o(eq), .more_o(gt), .bits_eq_o(weq)
  );

  function automatic logic f_lt(logic [W-1:0] x, logic [W-1:0] y, logic c);
    return (x < y) || ((x == y) && c);
  endfunction
  function automatic logic f_gt(logic [W-1:0] x, logic [W-1:0] y, logic c);
    return (x > y) || ((x == y) && c);
  endfunction
  function automatic logic f_eq(logic [W-1:0] x, logic [W-1:0] y, logic c);
    return (x == y) && c;
  endfunction

  task automatic chk(string tag, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s a=%h b=%h casc=%b%b%b got=%b exp=%b", tag, a, b, cl, ce, cg, got, exp);
    end
  endtask

  // Drive on the falling edge, sample 1 ns later (R9: no clock edge in between)
  task automatic apply(logic [W-1:0] x, logic [W-1:0] y, logic [2:0] c);
    @(negedge clk);
    a = x; b = y; {cl, ce, cg} = c;
    #1;
    chk("R1 less", lt, f_lt(x, y, c[2]));
    chk("R2 more", gt, f_gt(x, y, c[0]));
    chk("R3 same", eq, f_eq(x, y, c[1]));
    chk("R5 bits_eq", weq, (x == y));
  endtask

  initial begin
    a = '0; b = '0; {cl, ce, cg} = 3'b010;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    // Reset-time state: equal zero words, equal carried in
    chk("R3 initial same", eq, 1'b1);
    chk("R1 initial less", lt, 1'b0);

    // R1 R2 R3 R7: sweep the low slice, high slice equal, every one-hot cascade
    for (int c = 0; c < 3; c++) begin
      for (int p = 0; p < 256; p++) begin
        logic [2:0] cv;
        cv = 3'b001 << c;
        apply({4'h5, p[7:4]}, {4'h5, p[3:0]}, cv);
        total++;
        if ($countones({lt, eq, gt}) != 1) begin
          bad++;
          $display("FAIL R7 onehot got=%b%b%b exp=one set", lt, eq, gt);
        end
      end
    end

    // R4: high slice sweep with low slice A<B and cascade "more": high decides
    for (int p = 0; p < 256; p++) begin
      apply({p[7:4], 4'h2}, {p[3:0], 4'h9}, 3'b001);
      if (p[7:4] != p[3:0]) chk("R4 high slice decides", gt, (p[7:4] > p[3:0]));
    end

    // R6: single bit flip at each position, on several base words
    for (int base = 0; base < 4; base++) begin
      for (int k = 0; k < W; k++) begin
        logic [W-1:0] bw;
        bw = (base == 0) ? 8'h00 : (base == 1) ? 8'hFF : (base == 2) ? 8'hA5 : 8'h3C;
        apply(bw, bw ^ (8'h01 << k), 3'b010);
        chk("R6 bit flip clears bits_eq", weq, 1'b0);
      end
    end

    // R8: equal words pass non-one-hot cascade through
    apply(8'h77, 8'h77, 3'b000);
    chk("R8 all-zero cascade less", lt, 1'b0);
    chk("R8 all-zero cascade same", eq, 1'b0);
    chk("R8 all-zero cascade more", gt, 1'b0);
    apply(8'hC3, 8'hC3, 3'b111);
    chk("R8 all-one cascade less", lt, 1'b1);
    chk("R8 all-one cascade same", eq, 1'b1);
    chk("R8 all-one cascade more", gt, 1'b1);
    // R5: cascade inputs do not touch the bit chain
    chk("R5 bits_eq ignores cascade", weq, 1'b1);

    // R9 + boundaries
    apply(8'h00, 8'hFF, 3'b010);
    chk("R9 same-cycle response less", lt, 1'b1);
    apply(8'hFF, 8'h00, 3'b100);
    chk("R9 same-cycle response more", gt, 1'b1);

    // Seeded random words
    begin
      int unsigned s;
      s = $urandom(32'h1234);
      for (int n = 0; n < 2000; n++) begin
        logic [W-1:0] x, y;
        logic [2:0] cv;
        x = W'($urandom);
        y = (n % 4 == 0) ? x : W'($urandom);
        cv = 3'($urandom);
        apply(x, y, cv);
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule